// File: doc/BRIEF.md
# Interleaved SAR Section Sequencer

This block sequences eight identical successive-approximation conversion sections that run from one shared clock. A free-running sixteen-slot phase counter sets the frame. Each section walks through the same sixteen-slot schedule, and each section's schedule starts two clocks after the previous one. As a result, exactly one section samples the analog input on every second clock, and the combined sample rate is half the clock rate. The analog parts (comparators, DAC and reference ladder) sit outside the block. Each section receives a single comparator decision bit and drives out the trial code that its DAC should present.

A section's frame has six named states, in local slot order. **ST_ZERO** (slot 0) samples the reference zero. **ST_OFFS** (slot 1) is the offset compare. **ST_GAIN** (slot 2) is the gain compare. **ST_SAMP** (slot 3) samples the input. **ST_TRIAL** (slots 4..14) holds the eleven bit trials, MSB first. **ST_XFER** (slot 15) transfers the word. The transitions are ST_ZERO→ST_OFFS→ST_GAIN→ST_SAMP→ST_TRIAL. ST_TRIAL loops on itself while its bit index counts down from 10 to 0, and moves to ST_XFER after bit 0. ST_XFER returns to ST_ZERO. Section s is in local slot (phase + 16 − 2s) mod 16. Every transfer happens on a distinct odd phase. A shared output mux therefore reports each finished word as a one-cycle pulse together with the section index.

Top module: `sar_interleave_seq`

## Requirements
- R1: The phase output counts 0,1,…,15 and wraps to 0, advancing by one on every rising clock edge outside reset.
- R2: `sample_o[s]` is high exactly when the phase equals (3 + 2s) mod 16. On odd phases exactly one section samples, and on even phases none does.
- R3: `cal_o[s]` is high in local slots 0, 1 and 2 of section s (reference-zero sample, offset compare, gain compare) and low in all other slots.
- R4: In local slot 4+j (j = 0..10), section s drives `trial_o[s]` = 1 and a trial code on `trial_code_o[s*11 +: 11]`. The code holds the already-resolved upper bits, bit 10−j set to 1, and the lower bits at 0. Outside trial slots the code is 0.
- R5: At the edge that ends the trial slot for bit k, the section keeps bit k at 1 if `cmp_i[s]` is 1 and clears it if `cmp_i[s]` is 0. The comparator input is ignored in every non-trial slot.
- R6: In local slot 15 of a section, `done_o` is high for one cycle. `done_sect_o` carries the section index s, and `done_word_o` carries the 11-bit result. This happens at phase (15 + 2s) mod 16.
- R7: When bit 10 (the overrange bit) of a finished word is 1, `done_word_o` reports all eleven bits as 1.
- R8: A synchronous active-high reset sets the phase to 0, clears every section's register, and places section s in local slot (16 − 2s) mod 16. The block holds this state while reset is asserted.
- R9: After reset, a section reports no transfer until it has passed through its input-sample slot at least once.
- R10: The input-sample slot clears the section's register, so the first trial code of each conversion is exactly 0x400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 8 | Comparator decision per section, 1 keeps the trial bit |
| phase_o | output | 4 | Global frame phase 0..15 |
| sample_o | output | 8 | Input-sample strobe per section |
| cal_o | output | 8 | Calibration-slot strobe per section (slots 0..2) |
| trial_o | output | 8 | Bit-trial active per section |
| trial_code_o | output | 88 | Trial DAC code per section, section s at bits s*11 +: 11 |
| done_o | output | 1 | Finished-word pulse |
| done_sect_o | output | 3 | Index of the section whose word is reported |
| done_word_o | output | 11 | Finished word, clamped to all ones on overrange |

## Verification
All outputs are Moore decodes of section state, so every strobe, trial code and transfer describes the slot the block is in during that clock. A comparator bit that is valid at the rising edge ending trial slot k first shows up one clock later, in the next trial code. The full word appears in the transfer slot that follows the last trial. The bench steps a behavioural slot model on each rising edge, derives the comparator bit from a per-conversion target value, and compares every output on the falling edge of the same cycle. Each sampled value therefore belongs to exactly the slot that the model has just entered. A reset in mid-run checks the restart slots and the suppressed first transfers.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_ZERO,
        ST_OFFS,
        ST_GAIN,
        ST_SAMP,
        ST_TRIAL,
        ST_XFER
    } sect_state_e;

    localparam int SLOT_SAMP   = 3;
    localparam int SLOT_TRIAL0 = 4;

    // State occupied by a section at a given local slot
    function automatic sect_state_e slot_state(input int slot, input int bits);
        sect_state_e st;
        if (slot == 0)                        st = ST_ZERO;
        else if (slot == 1)                   st = ST_OFFS;
        else if (slot == 2)                   st = ST_GAIN;
        else if (slot == SLOT_SAMP)           st = ST_SAMP;
        else if (slot < SLOT_TRIAL0 + bits)   st = ST_TRIAL;
        else                                  st = ST_XFER;
        return st;
    endfunction

    // Bit under trial at a given local slot (MSB first)
    function automatic int slot_bit(input int slot, input int bits);
        int b;
        if (slot >= SLOT_TRIAL0 && slot < SLOT_TRIAL0 + bits)
            b = bits - 1 - (slot - SLOT_TRIAL0);
        else
            b = bits - 1;
        return b;
    endfunction

endpackage

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr #(
    parameter int FRAME = 16,
    localparam int PH_W = $clog2(FRAME)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_o
);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_d;

    always_comb begin
        if (phase_q == PH_W'(FRAME - 1))
            phase_d = '0;
        else
            phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/sar_section.sv
module sar_section
    import sar_seq_pkg::*;
#(
    parameter int BITS       = 11,
    parameter int START_SLOT = 0,
    localparam int BIT_W     = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_i,
    output logic            sample_o,
    output logic            cal_o,
    output logic            trial_o,
    output logic [BITS-1:0] trial_code_o,
    output logic            xfer_o,
    output logic [BITS-1:0] word_o
);

    localparam sect_state_e      RST_STATE = slot_state(START_SLOT, BITS);
    localparam logic [BIT_W-1:0] RST_BIT   = BIT_W'(slot_bit(START_SLOT, BITS));
    localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(BITS - 1);

    sect_state_e      state_q, state_d;
    logic [BIT_W-1:0] bit_q,   bit_d;
    logic [BITS-1:0]  sar_q,   sar_d;
    logic             primed_q, primed_d;

    // Next-state and register-update logic
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        sar_d    = sar_q;
        primed_d = primed_q;
        unique case (state_q)
            ST_ZERO:  state_d = ST_OFFS;
            ST_OFFS:  state_d = ST_GAIN;
            ST_GAIN:  state_d = ST_SAMP;
            ST_SAMP: begin
                sar_d    = '0;
                primed_d = 1'b1;
                bit_d    = TOP_BIT;
                state_d  = ST_TRIAL;
            end
            ST_TRIAL: begin
                sar_d[bit_q] = cmp_i;
                if (bit_q == '0)
                    state_d = ST_XFER;
                else
                    bit_d = bit_q - 1'b1;
            end
            ST_XFER:  state_d = ST_ZERO;
            default:  state_d = ST_ZERO;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RST_STATE;
            bit_q    <= RST_BIT;
            sar_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            bit_q    <= bit_d;
            sar_q    <= sar_d;
            primed_q <= primed_d;
        end
    end

    // Moore outputs
    always_comb begin
        sample_o     = 1'b0;
        cal_o        = 1'b0;
        trial_o      = 1'b0;
        trial_code_o = '0;
        xfer_o       = 1'b0;
        unique case (state_q)
            ST_ZERO, ST_OFFS, ST_GAIN: cal_o = 1'b1;
            ST_SAMP:  sample_o = 1'b1;
            ST_TRIAL: begin
                trial_o      = 1'b1;
                trial_code_o = sar_q | (BITS'(1) << bit_q);
            end
            ST_XFER:  xfer_o = primed_q;
            default:  cal_o = 1'b0;
        endcase
    end

    assign word_o = sar_q;

endmodule

// File: rtl/sar_done_mux.sv
module sar_done_mux #(
    parameter int N_SECT = 8,
    parameter int BITS   = 11,
    localparam int SEL_W = $clog2(N_SECT)
) (
    input  logic [N_SECT-1:0]      xfer_i,
    input  logic [N_SECT*BITS-1:0] words_i,
    output logic                   vld_o,
    output logic [SEL_W-1:0]       sect_o,
    output logic [BITS-1:0]        word_o
);

    logic [BITS-1:0] raw;

    always_comb begin
        raw    = '0;
        sect_o = '0;
        for (int i = 0; i < N_SECT; i++) begin
            if (xfer_i[i]) begin
                raw    = words_i[i*BITS +: BITS];
                sect_o = SEL_W'(i);
            end
        end
    end

    assign vld_o  = |xfer_i;
    assign word_o = raw[BITS-1] ? '1 : raw;

endmodule

// File: rtl/sar_interleave_seq.sv
module sar_interleave_seq
    import sar_seq_pkg::*;
#(
    parameter int N_SECT  = 8,
    parameter int BITS    = 11,
    parameter int STAGGER = 2,
    localparam int FRAME  = BITS + 5,
    localparam int PH_W   = $clog2(FRAME),
    localparam int SEL_W  = $clog2(N_SECT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_SECT-1:0]      cmp_i,
    output logic [PH_W-1:0]        phase_o,
    output logic [N_SECT-1:0]      sample_o,
    output logic [N_SECT-1:0]      cal_o,
    output logic [N_SECT-1:0]      trial_o,
    output logic [N_SECT*BITS-1:0] trial_code_o,
    output logic                   done_o,
    output logic [SEL_W-1:0]       done_sect_o,
    output logic [BITS-1:0]        done_word_o
);

    logic [N_SECT-1:0]      xfer;
    logic [N_SECT*BITS-1:0] words;

    sar_phase_ctr #(.FRAME(FRAME)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase_o)
    );

    for (genvar g = 0; g < N_SECT; g++) begin : g_sect
        localparam int START = (FRAME - ((STAGGER * g) % FRAME)) % FRAME;
        sar_section #(
            .BITS       (BITS),
            .START_SLOT (START)
        ) u_sect (
            .clk          (clk),
            .rst          (rst),
            .cmp_i        (cmp_i[g]),
            .sample_o     (sample_o[g]),
            .cal_o        (cal_o[g]),
            .trial_o      (trial_o[g]),
            .trial_code_o (trial_code_o[g*BITS +: BITS]),
            .xfer_o       (xfer[g]),
            .word_o       (words[g*BITS +: BITS])
        );
    end

    sar_done_mux #(.N_SECT(N_SECT), .BITS(BITS)) u_done (
        .xfer_i  (xfer),
        .words_i (words),
        .vld_o   (done_o),
        .sect_o  (done_sect_o),
        .word_o  (done_word_o)
    );

endmodule

// File: rtl/sar_interleave_seq_chk.sv
module sar_interleave_seq_chk #(
    parameter int N_SECT = 8,
    parameter int BITS   = 11,
    localparam int FRAME = BITS + 5,
    localparam int PH_W  = $clog2(FRAME),
    localparam int SEL_W = $clog2(N_SECT)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [PH_W-1:0]        phase_o,
    input logic [N_SECT-1:0]      sample_o,
    input logic [N_SECT-1:0]      cal_o,
    input logic [N_SECT-1:0]      trial_o,
    input logic                   done_o,
    input logic [BITS-1:0]        done_word_o
);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(FRAME - 1)) |=> (phase_o == '0)); // R1

    AST_RESET_PHASE: assert property (@(posedge clk)
        rst |=> (phase_o == '0)); // R8

    AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $countones(sample_o) == (phase_o[0] ? 1 : 0)); // R2

    AST_CAL_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(cal_o) == (phase_o[0] ? 1 : 2)); // R3

    AST_TRIAL_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(trial_o) == (phase_o[0] ? 5 : 6)); // R4

    AST_DONE_ODD: assert property (@(posedge clk) disable iff (rst)
        done_o |-> phase_o[0]); // R6

    AST_OVR_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_word_o[BITS-1]) |-> (&done_word_o)); // R7

endmodule

bind sar_interleave_seq sar_interleave_seq_chk #(
    .N_SECT (N_SECT),
    .BITS   (BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_o     (phase_o),
    .sample_o    (sample_o),
    .cal_o       (cal_o),
    .trial_o     (trial_o),
    .done_o      (done_o),
    .done_word_o (done_word_o)
);

// File: tb/sar_interleave_seq_tb.sv
`timescale 1ns/1ps
module sar_interleave_seq_tb;

    localparam int NS = 8;
    localparam int NB = 11;
    localparam int FR = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NS-1:0]    cmp_i = '0;
    logic [3:0]       phase_o;
    logic [NS-1:0]    sample_o, cal_o, trial_o;
    logic [NS*NB-1:0] trial_code_o;
    logic             done_o;
    logic [2:0]       done_sect_o;
    logic [NB-1:0]    done_word_o;

    sar_interleave_seq u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmp_i        (cmp_i),
        .phase_o      (phase_o),
        .sample_o     (sample_o),
        .cal_o        (cal_o),
        .trial_o      (trial_o),
        .trial_code_o (trial_code_o),
        .done_o       (done_o),
        .done_sect_o  (done_sect_o),
        .done_word_o  (done_word_o)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int msar[NS];
    int mtgt[NS];
    bit mprim[NS];
    bit started  = 0;
    bit finished = 0;
    int seed = 77;
    int tq[$] = '{0, 2047, 1023, 1024, 1, 512, 1535, 341, 682, 1100};

    function automatic int slot_of(int s, int c);
        return (c + FR - 2 * s) % FR;
    endfunction

    function automatic int next_target();
        int v;
        if (tq.size() > 0) v = tq.pop_front();
        else begin
            seed = (seed * 1103 + 517) % 2048;
            v = seed;
        end
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference: step on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            cyc = 0;
            for (int s = 0; s < NS; s++) begin
                msar[s] = 0;
                mprim[s] = 0;
            end
        end else begin
            for (int s = 0; s < NS; s++) begin
                int l;
                l = slot_of(s, cyc);
                if (l == 3) begin
                    msar[s] = 0;
                    mprim[s] = 1;
                    mtgt[s] = next_target();
                end else if (l >= 4 && l <= 14) begin
                    int k;
                    k = 14 - l;
                    if (cmp_i[s]) msar[s] = msar[s] | (1 << k);
                    else          msar[s] = msar[s] & ~(1 << k);
                end
            end
            cyc++;
        end
    end

    // Compare on the falling edge, then drive the comparator bits
    always @(negedge clk) begin
        if (started && !finished) begin
            int exp_done, exp_sect, exp_word;
            string tg;
            exp_done = 0; exp_sect = 0; exp_word = 0;
            check(phase_o == 4'(cyc % FR), rst ? "R8" : "R1", phase_o, cyc % FR);
            for (int s = 0; s < NS; s++) begin
                int l, ec;
                l = slot_of(s, cyc);
                check(sample_o[s] == (l == 3), rst ? "R8" : "R2", sample_o[s], l == 3);
                check(cal_o[s] == (l <= 2), rst ? "R8" : "R3", cal_o[s], l <= 2);
                check(trial_o[s] == (l >= 4 && l <= 14), "R4", trial_o[s], l >= 4 && l <= 14);
                ec = (l >= 4 && l <= 14) ? (msar[s] | (1 << (14 - l))) : 0;
                tg = (l == 4 && !rst) ? "R10" : (rst ? "R8" : "R4");
                check(trial_code_o[s*NB +: NB] == NB'(ec), tg, trial_code_o[s*NB +: NB], ec);
                if (l == 15 && mprim[s]) begin
                    exp_done = 1;
                    exp_sect = s;
                    exp_word = (msar[s] >= 1024) ? 2047 : msar[s];
                end
            end
            tg = (exp_done == 0 && !rst) ? "R9" : "R6";
            check(done_o == exp_done[0], tg, done_o, exp_done);
            if (exp_done != 0) begin
                check(done_sect_o == 3'(exp_sect), "R6", done_sect_o, exp_sect);
                check(done_word_o == NB'(exp_word), (exp_word == 2047) ? "R7" : "R5",
                      done_word_o, exp_word);
            end
        end
        // Comparator drive: decided from the model's target in trial slots,
        // a noise bit elsewhere (must be ignored, R5)
        for (int s = 0; s < NS; s++) begin
            int l;
            l = rst ? slot_of(s, 0) : slot_of(s, cyc);
            if (l >= 4 && l <= 14)
                cmp_i[s] <= ((msar[s] | (1 << (14 - l))) <= mtgt[s]);
            else
                cmp_i[s] <= ((cyc + s) % 3 == 0);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (420) @(negedge clk);
        rst = 1'b1;                 // mid-run reset, R8 and R9
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (260) @(negedge clk);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule